// File: doc/BRIEF.md
# Bus-Snooping Packet Checksum Unit

This unit forms the 16-bit one's-complement Internet checksum of a packet while the packet is copied once over the system bus, from the peripheral data handler into packet memory. It never drives the bus and never reads memory. It only observes write beats. Software programs a start command that holds the destination window (base byte address and length in 32-bit beats), the direction (transmit or receive) and a seed. The seed is normally the pseudo-header partial sum. Each write beat whose address falls inside the window is folded into the running sum. When the programmed number of beats has been seen, the unit reports the result and, in receive mode, a verify flag. Software uses that flag to decide whether the packet keeps its memory slot.

A small controller drives the unit. Its states are `ST_IDLE` (after reset; beats ignored), `ST_RUN` (counting window beats), `ST_FINISH` (one cycle in which the result is latched) and `ST_DONE` (result presented; beats ignored). The transitions are:

- start: any state goes to `ST_RUN` on a start command, or to `ST_FINISH` if the length is zero.
- last-beat: `ST_RUN` goes to `ST_FINISH` when the beat count reaches the length.
- latch: `ST_FINISH` goes to `ST_DONE` on the next clock.

Top module: `pkt_csum_snoop`

## Requirements
- R1: After reset `sts_busy`, `sts_done`, `sts_ok` are 0 and `sts_sum` is 0x0000.
- R2: A cycle with `cmd_start`=1 and nonzero `cmd_beats` makes `sts_busy`=1 and `sts_done`=0 from the next clock. It clears `sts_ok` and loads the accumulator with `cmd_seed`.
- R3: A beat is counted only when `bus_valid`=1, `bus_write`=1, the unit is running, and `base <= bus_addr < base + 4*beats`. Reads, out-of-window writes, and writes while idle or done leave the result unchanged.
- R4: Each counted beat adds `bus_data[31:16]` and `bus_data[15:0]` to the accumulator by one's-complement addition, with carries wrapped back into bit 0.
- R5: Byte lane k is `bus_data[8k+7:8k]` and is gated by `bus_strb[k]`. A gated-off lane contributes zero. A lone first byte (`bus_strb`=4'b1000) therefore counts as the high byte of a word whose low byte is zero.
- R6: If the last beat is captured at clock edge k, then `sts_busy` stays 1 and `sts_done` stays 0 after edge k. After edge k+1, `sts_done`=1 and `sts_busy`=0.
- R7: In transmit mode (`cmd_rx`=0), `sts_sum` is the bitwise inverse of the folded sum and `sts_ok` is 0.
- R8: In receive mode (`cmd_rx`=1), `sts_sum` is the folded sum. `sts_ok` is 1 exactly when that sum equals 0xFFFF.
- R9: A start with `cmd_beats`=0 reports a result built from the seed alone, two clocks later.
- R10: A start issued while running abandons the current packet and begins a fresh one with a new seed.
- R11: `sts_sum`, `sts_ok` and `sts_done` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Observed bus beat valid |
| bus_write | input | 1 | Observed beat is a write |
| bus_addr | input | AW | Observed byte address |
| bus_data | input | DW | Observed write data, first byte in the top lane |
| bus_strb | input | DW/8 | Observed byte strobes |
| cmd_start | input | 1 | One-cycle start command |
| cmd_rx | input | 1 | 1 = receive/verify, 0 = transmit |
| cmd_base | input | AW | Window base byte address |
| cmd_beats | input | LW | Packet length in bus beats |
| cmd_seed | input | 16 | Initial partial sum (pseudo-header) |
| sts_busy | output | 1 | Packet in progress |
| sts_done | output | 1 | Result valid |
| sts_ok | output | 1 | Receive checksum verified |
| sts_sum | output | 16 | Result checksum |

## Verification
A corrupted accumulator or a mis-gated lane does not show up until the packet ends. It then appears as a wrong `sts_sum` in the cycle that `sts_done` rises, so every packet is compared against a scoreboard entry at that moment. An error in the beat counter or the window shows up as `sts_done` rising one or more cycles early or late. The bench therefore pins the exact edges of R6, and mixes reads and just-outside writes into packets. State that leaks after done is caught by driving in-window beats after completion and checking that the result is unchanged.

// File: rtl/csum_pkg.sv
package csum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2,
        ST_DONE   = 2'd3
    } csum_state_e;
endpackage

// File: rtl/csum_beat_sum.sv
// Strobe-gates each byte lane and adds the 16-bit halves of one beat.
module csum_beat_sum #(
    parameter int DW = 32,
    parameter int SW = 17
) (
    input  logic [DW-1:0]   data,
    input  logic [DW/8-1:0] strb,
    output logic [SW-1:0]   total
);
    localparam int NL = DW / 8;
    localparam int NH = DW / 16;

    logic [DW-1:0] masked;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign masked[g*8 +: 8] = strb[g] ? data[g*8 +: 8] : 8'h00;
    end

    always_comb begin
        total = '0;
        for (int h = 0; h < NH; h++) begin
            total = total + SW'(masked[h*16 +: 16]);
        end
    end
endmodule

// File: rtl/csum_accum.sv
// One's-complement accumulator with end-around carry.
module csum_accum #(
    parameter int SW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [15:0]   seed,
    input  logic          add_en,
    input  logic [SW-1:0] addend,
    output logic [15:0]   acc
);
    localparam int XW = SW + 1;

    logic [XW-1:0] wide;
    logic [16:0]   fold1;
    logic [15:0]   fold2;

    always_comb begin
        wide  = XW'(acc) + XW'(addend);
        fold1 = 17'(wide[15:0]) + 17'(wide[XW-1:16]);
        fold2 = fold1[15:0] + 16'(fold1[16]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= 16'h0000;
        end else if (load) begin
            acc <= seed;
        end else if (add_en) begin
            acc <= fold2;
        end
    end

    // R4: end-around addition never turns a nonzero sum into zero
    a_r4_no_zero_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !load && acc != 16'h0000) |=> (acc != 16'h0000));
endmodule

// File: rtl/csum_window.sv
// Decides whether an observed beat is a write inside the packet window.
module csum_window #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] beats,
    output logic          hit
);
    localparam int EW = AW + 1;

    logic [EW-1:0] lo_b, hi_b, a_ext;

    always_comb begin
        lo_b  = EW'(base);
        hi_b  = EW'(base) + (EW'(beats) << 2);
        a_ext = EW'(addr);
        hit   = valid && write && (a_ext >= lo_b) && (a_ext < hi_b);
    end
endmodule

// File: rtl/pkt_csum_snoop.sv
module pkt_csum_snoop
    import csum_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_data,
    input  logic [DW/8-1:0] bus_strb,
    input  logic            cmd_start,
    input  logic            cmd_rx,
    input  logic [AW-1:0]   cmd_base,
    input  logic [LW-1:0]   cmd_beats,
    input  logic [15:0]     cmd_seed,
    output logic            sts_busy,
    output logic            sts_done,
    output logic            sts_ok,
    output logic [15:0]     sts_sum
);
    localparam int SW = 16 + $clog2(DW / 16);

    csum_state_e   state_q, state_d, start_tgt;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q, cnt_q;
    logic          rx_q, ok_q;
    logic [15:0]   sum_q, acc;
    logic [SW-1:0] beat_total;
    logic          hit, accept, last_beat;

    csum_window #(.AW(AW), .LW(LW)) u_win (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .base  (base_q),
        .beats (len_q),
        .hit   (hit)
    );

    csum_beat_sum #(.DW(DW), .SW(SW)) u_beat (
        .data  (bus_data),
        .strb  (bus_strb),
        .total (beat_total)
    );

    assign accept    = hit && (state_q == ST_RUN) && !cmd_start;
    assign last_beat = accept && ((LW+1)'(cnt_q) + (LW+1)'(1) == (LW+1)'(len_q));

    csum_accum #(.SW(SW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cmd_start),
        .seed   (cmd_seed),
        .add_en (accept),
        .addend (beat_total),
        .acc    (acc)
    );

    // Next-state logic
    always_comb begin
        start_tgt = (cmd_beats == '0) ? ST_FINISH : ST_RUN;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_start) state_d = start_tgt;
            ST_RUN:    if (cmd_start) state_d = start_tgt;
                       else if (last_beat) state_d = ST_FINISH;
            ST_FINISH: if (cmd_start) state_d = start_tgt;
                       else state_d = ST_DONE;
            ST_DONE:   if (cmd_start) state_d = start_tgt;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command capture, beat counter and result latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            rx_q   <= 1'b0;
            ok_q   <= 1'b0;
            sum_q  <= 16'h0000;
        end else if (cmd_start) begin
            base_q <= cmd_base;
            len_q  <= cmd_beats;
            cnt_q  <= '0;
            rx_q   <= cmd_rx;
            ok_q   <= 1'b0;
        end else begin
            if (accept) cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_FINISH) begin
                sum_q <= rx_q ? acc : ~acc;
                ok_q  <= rx_q && (acc == 16'hFFFF);
            end
        end
    end

    // Outputs
    always_comb begin
        sts_busy = (state_q == ST_RUN) || (state_q == ST_FINISH);
        sts_done = (state_q == ST_DONE);
        sts_ok   = ok_q;
        sts_sum  = sum_q;
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_beats != '0) |=> (sts_busy && !sts_done && !sts_ok));
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q < len_q));
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_busy && sts_done));
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_done) |-> $past(sts_busy));
    a_r8_ok_only_rx_done: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ok |-> (sts_done && rx_q));
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_done && !cmd_start) |=> (sts_done && $stable(sts_sum) && $stable(sts_ok)));
endmodule

// File: tb/pkt_csum_snoop_tb.sv
`timescale 1ns/1ps
module pkt_csum_snoop_tb;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] BASE = 16'h0100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_data = '0;
    logic [DW/8-1:0] bus_strb = '0;
    logic            cmd_start = 1'b0, cmd_rx = 1'b0;
    logic [AW-1:0]   cmd_base = '0;
    logic [LW-1:0]   cmd_beats = '0;
    logic [15:0]     cmd_seed = '0;
    logic            sts_busy, sts_done, sts_ok;
    logic [15:0]     sts_sum;

    int checks = 0;
    int bad = 0;
    logic [16:0] exp_q[$];
    logic [31:0] bd[0:15];
    logic [3:0]  bs[0:15];

    always #2.5 clk = ~clk;

    pkt_csum_snoop #(.AW(AW), .LW(LW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_strb(bus_strb),
        .cmd_start(cmd_start), .cmd_rx(cmd_rx), .cmd_base(cmd_base),
        .cmd_beats(cmd_beats), .cmd_seed(cmd_seed),
        .sts_busy(sts_busy), .sts_done(sts_done), .sts_ok(sts_ok), .sts_sum(sts_sum)
    );

    task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'h0, s[16]};
    endfunction

    // Reference sum from R4/R5: lane k gated by strobe k, halves added with wrap
    function automatic logic [15:0] model(input logic [15:0] seed, input int n);
        logic [15:0] a;
        logic [31:0] m;
        a = seed;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 4; k++) m[k*8 +: 8] = bs[i][k] ? bd[i][k*8 +: 8] : 8'h00;
            a = oc_add(a, m[31:16]);
            a = oc_add(a, m[15:0]);
        end
        return a;
    endfunction

    task automatic beat(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s, input bit wr);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_data = d; bus_strb = s;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic issue_start(input bit rx, input logic [15:0] seed, input int n);
        cmd_start = 1'b1; cmd_rx = rx; cmd_base = BASE; cmd_beats = LW'(n); cmd_seed = seed;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    // Driver: pushes the expected result, then replays the packet on the bus
    task automatic run_pkt(input bit rx, input logic [15:0] seed, input int n, input bit junk);
        logic [15:0] f;
        f = model(seed, n);
        exp_q.push_back(rx ? {(f == 16'hFFFF), f} : {1'b0, ~f});
        issue_start(rx, seed, n);
        check(sts_busy && !sts_done && !sts_ok, "R2 busy after start",
              {29'h0, sts_busy, sts_done, sts_ok}, 32'h4);
        for (int i = 0; i < n; i++) begin
            if (junk) begin
                beat(BASE + AW'(4*i), 32'hDEAD_BEEF, 4'hF, 1'b0);   // read
                beat(BASE - AW'(4), 32'h1111_2222, 4'hF, 1'b1);     // below window
                beat(BASE + AW'(4*n), 32'h3333_4444, 4'hF, 1'b1);   // just above window
            end
            beat(BASE + AW'(4*i), bd[i], bs[i], 1'b1);
        end
        check(sts_busy && !sts_done, "R6 not done at capture edge",
              {30'h0, sts_busy, sts_done}, 32'h2);
        @(negedge clk);
        check(sts_done && !sts_busy, "R6 done one cycle later",
              {30'h0, sts_busy, sts_done}, 32'h1);
    endtask

    // Monitor: compares each result as done rises
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (sts_done && !done_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected result", {16'h0, sts_sum}, 32'h0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check(sts_sum == e[15:0], "R4/R7/R8 sum", {16'h0, sts_sum}, {16'h0, e[15:0]});
                check(sts_ok == e[16], "R8 ok flag", {31'h0, sts_ok}, {31'h0, e[16]});
            end
        end
        done_prev = sts_done;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [15:0] s, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!sts_busy && !sts_done && !sts_ok && sts_sum == 16'h0, "R1 reset",
              {13'h0, sts_busy, sts_done, sts_ok, sts_sum}, 32'h0);
        // R3: beats while idle leave outputs idle
        beat(BASE, 32'hFFFF_FFFF, 4'hF, 1'b1);
        check(!sts_busy && !sts_done, "R3 idle beat ignored", {30'h0, sts_busy, sts_done}, 32'h0);

        // R4/R7: transmit, full strobes
        bd[0] = 32'h4500_0073; bd[1] = 32'h0000_4000; bd[2] = 32'h4011_C0A8;
        for (int i = 0; i < 3; i++) bs[i] = 4'hF;
        run_pkt(1'b0, 16'h1234, 3, 1'b0);

        // R3/R11: in-window beat after done leaves the result unchanged
        held = sts_sum;
        beat(BASE, 32'h0F0F_0F0F, 4'hF, 1'b1);
        @(negedge clk);
        check(sts_done && sts_sum == held, "R3 R11 beat after done ignored",
              {15'h0, sts_done, sts_sum}, {15'h0, 1'b1, held});

        // R4: carry wrap with all-ones data
        bd[0] = 32'hFFFF_FFFF; bd[1] = 32'hFFFF_0001; bs[0] = 4'hF; bs[1] = 4'hF;
        run_pkt(1'b0, 16'hFFFF, 2, 1'b0);

        // R3: reads and out-of-window writes interleaved
        bd[0] = 32'hA1B2_C3D4; bd[1] = 32'h0102_0304; bd[2] = 32'hFEDC_BA98; bd[3] = 32'h5555_AAAA;
        for (int i = 0; i < 4; i++) bs[i] = 4'hF;
        run_pkt(1'b0, 16'h0042, 4, 1'b1);

        // R5: partial strobes and lone trailing byte
        bd[0] = 32'h1122_3344; bs[0] = 4'b0011;
        bd[1] = 32'h5566_7788; bs[1] = 4'b0110;
        bd[2] = 32'hAB99_8877; bs[2] = 4'b1000;
        run_pkt(1'b0, 16'h0000, 3, 1'b0);

        // R8: receive, valid checksum field in last beat -> ok
        bd[0] = 32'h6000_1234; bd[1] = 32'hBEEF_0102; bs[0] = 4'hF; bs[1] = 4'hF;
        s = model(16'h0AB0, 2);
        bd[2] = {16'h0000, ~s}; bs[2] = 4'hF;
        run_pkt(1'b1, 16'h0AB0, 3, 1'b0);
        check(sts_ok, "R8 verified packet ok", {31'h0, sts_ok}, 32'h1);

        // R8: receive, corrupted checksum field -> not ok
        bd[2] = {16'h0000, ~s ^ 16'h0100};
        run_pkt(1'b1, 16'h0AB0, 3, 1'b1);
        check(!sts_ok, "R8 corrupted packet rejected", {31'h0, sts_ok}, 32'h0);

        // R9: zero-length packet reports seed-only result
        run_pkt(1'b0, 16'h7F00, 0, 1'b0);
        check(sts_sum == 16'h80FF, "R9 zero length sum", {16'h0, sts_sum}, 32'h80FF);

        // R10: restart mid-packet abandons the first one
        issue_start(1'b0, 16'hAAAA, 4);
        beat(BASE, 32'h1234_5678, 4'hF, 1'b1);
        beat(BASE + 16'h4, 32'h9ABC_DEF0, 4'hF, 1'b1);
        check(sts_busy && !sts_done, "R10 still running before restart",
              {30'h0, sts_busy, sts_done}, 32'h2);
        bd[0] = 32'h0000_0001; bd[1] = 32'h0002_0000; bs[0] = 4'hF; bs[1] = 4'hF;
        run_pkt(1'b0, 16'h0010, 2, 1'b0);
        check(sts_sum == 16'hFFEC, "R10 restarted sum", {16'h0, sts_sum}, 32'hFFEC);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 32'h0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule